// File: doc/BRIEF.md
# Receive FIFO with Trigger-Level Signalling

This block is the receive-side character buffer of one asynchronous serial channel. The deserializer pushes each finished character into it with a single-cycle strobe. The character is a byte plus a small set of per-character error flags, and the flags travel through the buffer together with their byte. The host pops characters with a read strobe. The registered read port shows the popped byte and its flags from the cycle after the strobe.

The block does not report full or empty. It reports how full it is through two request lines. The data-available interrupt request rises when the fill level reaches one of four programmable thresholds. The DMA ready request has two modes. In per-character mode it is high while any character waits. In block mode it rises at the threshold and stays high until the buffer drains completely. A flush input empties the buffer in one cycle and leaves the threshold and mode settings alone. When buffering is switched off, the block acts as a single-character holding register.

The DMA request in block mode is produced by a two-state machine:
- `REQ_IDLE`: no latched request.
- `REQ_HELD`: a request latched at the threshold.

It has two transitions:
- `ARM`: `REQ_IDLE` to `REQ_HELD`, taken when the fill level is at or above the threshold.
- `DRAIN`: `REQ_HELD` to `REQ_IDLE`, taken when the fill level is zero, on flush, or when block mode is not selected.

Top module: `rx_fifo_trig`

## Requirements
- R1: After `rst_n` is released, `rx_avail_irq`, `rxrdy` and `overrun` are 0, `rd_data` is 0x00 and `rd_flags` is 0.
- R2: With `buf_en`=1 the buffer holds 16 characters. Characters are read back in the order written, each byte with the flags written alongside it. `rd_data`/`rd_flags` change on the clock edge that samples `rd_en`.
- R3: `trig_sel` picks the threshold: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 characters. With `rx_int_en`=1, `rx_avail_irq` is high in the same cycle the fill level becomes at or above the threshold.
- R4: `rx_avail_irq` falls in the cycle the fill level drops below the threshold. It stays 0 at any level while `rx_int_en`=0.
- R5: With `dma_mode`=0 and `buf_en`=1, `rxrdy` is high exactly when at least one character is stored.
- R6: With `dma_mode`=1 and `buf_en`=1, `rxrdy` rises when the fill level reaches the threshold. It then stays high through reads until the buffer is empty, and falls in that cycle.
- R7: A one-cycle `flush` empties the buffer and cancels any latched DMA request. It takes priority over a write or read in the same cycle. It does not change the effect of `trig_sel` or `dma_mode`.
- R8: A read strobe while the buffer is empty leaves `rd_data`/`rd_flags` at their previous value and moves no pointer. The next written character is the next one read.
- R9: A write while the buffer holds its full capacity is dropped, even if a read happens in the same cycle. `overrun` is high for exactly the one cycle after that write, and the stored characters are unchanged.
- R10: With `buf_en`=0 the capacity is one character and the threshold is 1. `rxrdy` follows per-character behaviour whatever `dma_mode` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Deserializer push strobe |
| wr_data | input | 8 | Received byte |
| wr_flags | input | 3 | Error flags of the received byte |
| rd_en | input | 1 | Host pop strobe |
| buf_en | input | 1 | 1 = 16-deep buffering, 0 = single holding register |
| flush | input | 1 | Empty the buffer in one cycle |
| dma_mode | input | 1 | 0 = per-character DMA request, 1 = block request |
| trig_sel | input | 2 | Threshold select |
| rx_int_en | input | 1 | Data-available interrupt enable |
| rd_data | output | 8 | Last popped byte |
| rd_flags | output | 3 | Flags of the last popped byte |
| rx_avail_irq | output | 1 | Data-available interrupt request |
| rxrdy | output | 1 | DMA receive-ready request |
| overrun | output | 1 | One-cycle pulse on a dropped write |

## Verification
The bench goes after these corner cases:
- Each threshold edge, stepping one character below and then onto each of the four levels. A wrong level decode would raise the interrupt a character early or late.
- The block-mode hysteresis, draining from above the threshold down to one character. A design that reused the threshold compare would drop `rxrdy` too early.
- Full-buffer pushes, which must be dropped with a single pulse. A design that let the write through would wrap the write pointer and corrupt the oldest character.
- Empty reads, which must not disturb the read pointer. A design that advanced it would return stale data after the next write.
- A flush, checked to confirm that the threshold setting survives it.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic {
        REQ_IDLE = 1'b0,
        REQ_HELD = 1'b1
    } req_state_t;

    // Threshold for a select code, scaled to the buffer depth.
    function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return depth / 4;
            2'b10:   return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int unsigned ENT_W = 11,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic             rd_en,
    input  logic [CNT_W-1:0] cap,
    output logic [CNT_W-1:0] level,
    output logic [ENT_W-1:0] rd_ent,
    output logic             ovr
);
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             full, take_wr, take_rd;

    assign full    = (level >= cap);
    assign take_wr = wr_en && !full && !flush;
    assign take_rd = rd_en && (level != '0) && !flush;

    always_ff @(posedge clk) begin
        if (take_wr) begin
            mem[wptr] <= wr_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            level  <= '0;
            rd_ent <= '0;
            ovr    <= 1'b0;
        end else if (flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
            ovr   <= 1'b0;
        end else begin
            ovr <= wr_en && full;
            if (take_wr) begin
                wptr <= wptr + 1'b1;
            end
            if (take_rd) begin
                rptr   <= rptr + 1'b1;
                rd_ent <= mem[rptr];
            end
            unique case ({take_wr, take_rd})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/rxf_dma_fsm.sv
module rxf_dma_fsm #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             blk_mode,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] trig,
    output logic             req
);
    import rxf_pkg::*;

    req_state_t state, state_nx;
    logic       at_trig, is_empty;

    assign at_trig  = (level >= trig);
    assign is_empty = (level == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= REQ_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        req      = 1'b0;
        unique case (state)
            REQ_IDLE: begin
                req = blk_mode && at_trig;
                if (blk_mode && at_trig && !flush) begin
                    state_nx = REQ_HELD;  // ARM
                end
            end
            REQ_HELD: begin
                req = blk_mode && !is_empty;
                if (is_empty || flush || !blk_mode) begin
                    state_nx = REQ_IDLE;  // DRAIN
                end
            end
            default: state_nx = REQ_IDLE;
        endcase
    end
endmodule

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned FLAG_W = 3,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              rd_en,
    input  logic              buf_en,
    input  logic              flush,
    input  logic              dma_mode,
    input  logic [1:0]        trig_sel,
    input  logic              rx_int_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [FLAG_W-1:0] rd_flags,
    output logic              rx_avail_irq,
    output logic              rxrdy,
    output logic              overrun
);
    import rxf_pkg::*;

    localparam int unsigned ENT_W = DATA_W + FLAG_W;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] level, cap, trig;
    logic [ENT_W-1:0] rd_ent;
    logic             blk_req, blk_mode;

    assign cap      = buf_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign trig     = buf_en ? CNT_W'(trig_level(trig_sel, DEPTH)) : CNT_W'(1);
    assign blk_mode = buf_en && dma_mode;

    rxf_store #(.ENT_W(ENT_W), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (wr_en),
        .wr_ent ({wr_flags, wr_data}),
        .rd_en  (rd_en),
        .cap    (cap),
        .level  (level),
        .rd_ent (rd_ent),
        .ovr    (overrun)
    );

    rxf_dma_fsm #(.CNT_W(CNT_W)) u_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .blk_mode (blk_mode),
        .level    (level),
        .trig     (trig),
        .req      (blk_req)
    );

    assign {rd_flags, rd_data} = rd_ent;
    assign rx_avail_irq        = rx_int_en && (level >= trig);
    assign rxrdy               = blk_mode ? blk_req : (level != '0);
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             flush,
    input logic             buf_en,
    input logic             dma_mode,
    input logic [CNT_W-1:0] level,
    input logic [7:0]       rd_data,
    input logic             rxrdy,
    input logic             rx_avail_irq,
    input logic             overrun
);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNT_W'(DEPTH));

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(wr_en));

    // R9
    ovr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !$past(wr_en, 2)) |=> !overrun);

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == '0) |=> $stable(rd_data));

    // R4
    irq_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail_irq |-> (level != '0));

    // R6
    blk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en && dma_mode && rxrdy && !flush) |=> (rxrdy || level == '0 || !buf_en));
endmodule

bind rx_fifo_trig rxf_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .flush        (flush),
    .buf_en       (buf_en),
    .dma_mode     (dma_mode),
    .level        (level),
    .rd_data      (rd_data),
    .rxrdy        (rxrdy),
    .rx_avail_irq (rx_avail_irq),
    .overrun      (overrun)
);

// File: tb/tb_rx_fifo_trig.sv
module tb_rx_fifo_trig;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] wr_flags = '0;
    logic       rd_en = 1'b0;
    logic       buf_en = 1'b1;
    logic       flush = 1'b0;
    logic       dma_mode = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic       rx_int_en = 1'b1;
    logic [7:0] rd_data;
    logic [2:0] rd_flags;
    logic       rx_avail_irq, rxrdy, overrun;

    int total = 0;
    int bad = 0;
    logic ovr_seen;

    always #5 clk = ~clk;

    rx_fifo_trig dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_flags(wr_flags),
        .rd_en(rd_en), .buf_en(buf_en), .flush(flush), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .rx_int_en(rx_int_en), .rd_data(rd_data), .rd_flags(rd_flags),
        .rx_avail_irq(rx_avail_irq), .rxrdy(rxrdy), .overrun(overrun)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] f);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_flags = f;
        @(negedge clk);
        wr_en = 1'b0;
        ovr_seen = overrun;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        check("R1", "irq after reset", rx_avail_irq, 0);
        check("R1", "rxrdy after reset", rxrdy, 0);
        check("R1", "overrun after reset", overrun, 0);
        check("R1", "rd_data after reset", rd_data, 0);
        check("R1", "rd_flags after reset", rd_flags, 0);
    endtask

    task automatic t_order();
        do_flush();
        buf_en = 1; trig_sel = 2'b00; rx_int_en = 1; dma_mode = 0;
        push(8'h5A, 3'd6);
        check("R3", "irq at level 1 (sel 00)", rx_avail_irq, 1);
        for (int i = 1; i < 16; i++) push(8'(i * 17 + 3), 3'(i));
        pop();
        check("R2", "first byte", rd_data, 8'h5A);
        check("R2", "first flags", rd_flags, 6);
        for (int i = 1; i < 16; i++) begin
            pop();
            check("R2", $sformatf("byte %0d", i), rd_data, (i * 17 + 3) % 256);
            check("R2", $sformatf("flags %0d", i), rd_flags, i % 8);
        end
        check("R4", "irq after drain", rx_avail_irq, 0);
    endtask

    task automatic t_trig();
        for (int s = 1; s < 4; s++) begin
            int lvl;
            lvl = (s == 1) ? 4 : (s == 2) ? 8 : 14;
            do_flush();
            trig_sel = 2'(s); rx_int_en = 1;
            for (int k = 0; k < lvl - 1; k++) push(8'(k), 3'd0);
            check("R3", $sformatf("irq one below sel %0d", s), rx_avail_irq, 0);
            push(8'hEE, 3'd0);
            check("R3", $sformatf("irq at level sel %0d", s), rx_avail_irq, 1);
            pop();
            check("R4", $sformatf("irq after drop sel %0d", s), rx_avail_irq, 0);
        end
        push(8'h11, 3'd0);
        rx_int_en = 0;
        #1;
        check("R4", "irq masked by enable", rx_avail_irq, 0);
        rx_int_en = 1;
    endtask

    task automatic t_dma0();
        do_flush();
        dma_mode = 0; trig_sel = 2'b11;
        check("R5", "rxrdy empty", rxrdy, 0);
        push(8'h21, 3'd0);
        check("R5", "rxrdy with one char", rxrdy, 1);
        pop();
        check("R5", "rxrdy drained", rxrdy, 0);
    endtask

    task automatic t_dma1();
        do_flush();
        dma_mode = 1; trig_sel = 2'b10;
        for (int k = 0; k < 7; k++) push(8'(k), 3'd0);
        check("R6", "rxrdy below threshold", rxrdy, 0);
        push(8'h07, 3'd0);
        check("R6", "rxrdy at threshold", rxrdy, 1);
        for (int k = 0; k < 7; k++) pop();
        check("R6", "rxrdy held at one char", rxrdy, 1);
        pop();
        check("R6", "rxrdy after empty", rxrdy, 0);
        dma_mode = 0;
    endtask

    task automatic t_flush();
        do_flush();
        trig_sel = 2'b01; dma_mode = 1;
        for (int k = 0; k < 5; k++) push(8'h40 + 8'(k), 3'd1);
        check("R6", "rxrdy armed before flush", rxrdy, 1);
        do_flush();
        check("R7", "irq after flush", rx_avail_irq, 0);
        check("R7", "rxrdy after flush", rxrdy, 0);
        for (int k = 0; k < 3; k++) push(8'h90 + 8'(k), 3'd2);
        check("R7", "threshold kept: 3 below 4", rx_avail_irq, 0);
        push(8'h93, 3'd2);
        check("R7", "threshold kept: irq at 4", rx_avail_irq, 1);
        check("R7", "block mode kept", rxrdy, 1);
        pop();
        check("R7", "first byte after flush", rd_data, 8'h90);
        dma_mode = 0;
    endtask

    task automatic t_empty_read();
        do_flush();
        push(8'hC3, 3'd5);
        pop();
        pop();
        check("R8", "empty read keeps data", rd_data, 8'hC3);
        check("R8", "empty read keeps flags", rd_flags, 5);
        push(8'h3C, 3'd4);
        pop();
        check("R8", "next write read after empty read", rd_data, 8'h3C);
    endtask

    task automatic t_overrun();
        do_flush();
        for (int k = 0; k < 16; k++) push(8'hA0 + 8'(k), 3'd0);
        check("R9", "no overrun at exact full", ovr_seen, 0);
        push(8'hFF, 3'd7);
        check("R9", "overrun pulse", ovr_seen, 1);
        @(negedge clk);
        check("R9", "overrun one cycle", overrun, 0);
        for (int k = 0; k < 16; k++) begin
            pop();
            check("R9", $sformatf("stored byte %0d kept", k), rd_data, 8'hA0 + k);
        end
        check("R9", "dropped byte absent", rxrdy, 0);
    endtask

    task automatic t_nobuf();
        do_flush();
        buf_en = 0; dma_mode = 1; trig_sel = 2'b11;
        push(8'h66, 3'd3);
        check("R10", "rxrdy per char when off", rxrdy, 1);
        check("R10", "irq threshold 1 when off", rx_avail_irq, 1);
        push(8'h77, 3'd0);
        check("R10", "second char overruns", ovr_seen, 1);
        pop();
        check("R10", "holding byte", rd_data, 8'h66);
        check("R10", "rxrdy clear after read", rxrdy, 0);
        buf_en = 1; dma_mode = 0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_trig();
        t_dma0();
        t_dma1();
        t_flush();
        t_empty_read();
        t_overrun();
        t_nobuf();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule